// File: doc/BRIEF.md
# Minterm Order Convergence Checker

This block inspects a proposed visiting order for the rows of an n-bit reversible function. Such an order drives a row-by-row synthesis loop. The order arrives as a stream of minterms, one per clock, with a valid strobe and an end-of-stream marker. An order is usable only when each new minterm can still be changed without disturbing rows already completed. That fails when the set bits of a new minterm are all contained in the set bits of some earlier minterm, so that it is bitwise dominated. Such an order is said to block, and the block rejects it.

The checker stores every minterm accepted so far in the current stream. It compares each arriving minterm against all stored ones in parallel, in the same cycle. It also enforces three structural rules: the stream must start with the all-zeros minterm, must hold exactly 2^N entries, and must end with the all-ones minterm. One cycle after the end marker it pulses a result strobe, a pass flag and the zero-based position of the first offending minterm. It then clears itself for the next stream.

Top module: `order_block_chk`

## Requirements
- R1: After reset, `res_valid` is low until the first end-of-stream beat has been accepted.
- R2: A stream whose position 0 is not the all-zeros minterm fails with `res_idx` = 0.
- R3: A minterm L at position p fails the stream when some earlier minterm E of the same stream has (L & E) == L. For example, 101 after 111 fails, and `res_idx` = p.
- R4: A minterm that is not bitwise contained in any earlier one is accepted. For example, 101 after 011 does not fail.
- R5: A repeated minterm fails at the position of the repeat.
- R6: A stream whose end marker arrives at a position other than 2^N-1 fails, with `res_idx` equal to that position unless an earlier failure exists.
- R7: A stream that does not end with the all-ones minterm never passes.
- R8: Only the first failing position is reported. Later violations in the same stream do not change `res_idx`.
- R9: `res_valid` pulses for exactly one cycle, one cycle after the end-of-stream beat. A stream that starts on the next beat is judged independently. On a pass, `res_idx` is 0.
- R10: For N = 3, the natural order and the order 0,2,1,3,4,6,5,7 pass, and exactly 48 of the 720 orders with 0 first and 7 last pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Minterm beat present |
| in_last | input | 1 | Beat is the final one of the stream |
| in_term | input | N | Minterm at the current position |
| res_valid | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | Order is free of blocking and well formed |
| res_idx | output | N+1 | First failing position, 0 on pass |

## Verification
The hardest condition to reach from the ports is a clean order that differs from another clean order only in subtle positions. Hand-picked streams cover only a handful of these. The bench therefore enumerates every permutation of the six middle minterms for N = 3 and decides each stream's verdict from the subset rule directly. It then checks each verdict and the first failing position, and confirms that the total number of passing orders is 48. Directed streams separately place a violation after an earlier one, to show that only the first is kept.

// File: rtl/order_block_chk.sv
module order_block_chk #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_last,
  input  logic [N-1:0] in_term,
  output logic         res_valid,
  output logic         res_pass,
  output logic [N:0]   res_idx
);
  localparam int LEN = 1 << N;
  localparam int CW  = N + 1;

  logic [CW-1:0]  cnt;
  logic [LEN-1:0] seen;
  logic [N-1:0]   tbl [LEN];
  logic           bad;
  logic [CW-1:0]  bad_idx;
  logic [LEN-1:0] dom;

  for (genvar i = 0; i < LEN; i++) begin : g_cmp
    assign dom[i] = seen[i] && ((in_term & tbl[i]) == in_term);
  end

  wire hit      = |dom;
  wire zero_bad = (cnt == '0) && (in_term != '0);
  wire len_bad  = in_last && (cnt != CW'(LEN - 1));
  wire viol     = hit || zero_bad || len_bad;
  wire room     = cnt < CW'(LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      seen      <= '0;
      bad       <= 1'b0;
      bad_idx   <= '0;
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= 1'b0;
      if (in_valid) begin
        if (in_last) begin
          res_valid <= 1'b1;
          res_pass  <= !(bad || viol);
          res_idx   <= bad ? bad_idx : (viol ? cnt : '0);
          cnt       <= '0;
          seen      <= '0;
          bad       <= 1'b0;
          bad_idx   <= '0;
        end else begin
          if (!bad && viol) begin
            bad     <= 1'b1;
            bad_idx <= cnt;
          end
          if (room) begin
            seen[cnt[N-1:0]] <= 1'b1;
            cnt              <= cnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && room) tbl[cnt[N-1:0]] <= in_term;
  end

  a_r9_result_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_last));

  a_r2_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt == '0 && in_term != '0) |=> (res_valid ? !res_pass : bad));

  a_r3_dominated: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit) |=> (res_valid ? !res_pass : bad));

  a_r7_last_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && in_term != '1) |=> !res_pass);

  a_r6_length: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && cnt != CW'(LEN - 1)) |=> !res_pass);

  a_r8_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && in_valid && !in_last) |=> (bad && $stable(bad_idx)));
endmodule

// File: tb/order_block_chk_tb.sv
module order_block_chk_tb;
  localparam int N = 3;
  localparam int LEN = 8;
  localparam time PERIOD = 10;

  logic clk = 0, rst_n = 0, in_valid = 0, in_last = 0;
  logic [N-1:0] in_term = '0;
  logic res_valid, res_pass;
  logic [N:0] res_idx;
  int checks = 0, fails = 0;
  bit done = 0;

  order_block_chk #(.N(N)) u_dut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int s[16], input int len, input bit ep,
                     input int ei, input string req);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_term = s[i][N-1:0]; in_last = (i == len - 1);
      if (i < len - 1) begin
        @(posedge clk); #1;
        chk({req, " no early result"}, int'(res_valid), 0);
      end
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    chk({req, " valid"}, int'(res_valid), 1);
    chk({req, " pass"}, int'(res_pass), int'(ep));
    chk({req, " idx"}, int'(res_idx), ei);
    @(negedge clk);
    chk({req, " one-cycle pulse"}, int'(res_valid), 0);
  endtask

  function automatic int ref_idx(input int s[16], input int len);
    for (int p = 0; p < len; p++) begin
      if (p == 0 && s[0] != 0) return 0;
      for (int q = 0; q < p; q++)
        if ((s[p] & s[q]) == s[p]) return p;
    end
    if (len != LEN) return len - 1;
    return -1;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset", int'(res_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", int'(res_valid), 0);
  endtask

  task automatic t_directed();
    int s[16];
    s = '{0,1,2,3,4,5,6,7,0,0,0,0,0,0,0,0}; run(s, 8, 1, 0, "R10 natural");
    s = '{0,2,1,3,4,6,5,7,0,0,0,0,0,0,0,0}; run(s, 8, 1, 0, "R10 alt");
    s = '{0,1,2,4,3,5,6,7,0,0,0,0,0,0,0,0}; run(s, 8, 1, 0, "R4 101 after 011");
    s = '{1,0,2,3,4,5,6,7,0,0,0,0,0,0,0,0}; run(s, 8, 0, 0, "R2 nonzero first");
    s = '{0,1,2,4,7,5,3,6,0,0,0,0,0,0,0,0}; run(s, 8, 0, 5, "R3 101 after 111");
    s = '{0,1,1,2,4,3,5,7,0,0,0,0,0,0,0,0}; run(s, 8, 0, 2, "R5 repeat");
    s = '{0,1,2,3,7,0,0,0,0,0,0,0,0,0,0,0}; run(s, 5, 0, 4, "R6 short");
    s = '{0,1,2,4,3,5,7,6,0,0,0,0,0,0,0,0}; run(s, 8, 0, 7, "R7 not ones last");
    s = '{0,3,1,2,2,4,5,7,0,0,0,0,0,0,0,0}; run(s, 8, 0, 2, "R8 first kept");
  endtask

  task automatic t_back_to_back();
    int a[16] = '{0,1,2,3,4,5,7,6,0,0,0,0,0,0,0,0};
    int b[16] = '{0,4,2,1,6,5,3,7,0,0,0,0,0,0,0,0};
    run(a, 8, 0, 7, "R9 first of pair");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1; in_term = b[i][N-1:0]; in_last = (i == 7);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    chk("R9 second valid", int'(res_valid), 1);
    chk("R9 second pass", int'(res_pass), 1);
    chk("R9 pass idx zero", int'(res_idx), 0);
  endtask

  task automatic t_exhaustive();
    int passes = 0;
    int bad = 0;
    for (int k = 0; k < 46656; k++) begin
      int d[6];
      int s[16];
      bit uniq = 1;
      int v = k;
      int e;
      for (int j = 0; j < 6; j++) begin d[j] = v % 6 + 1; v = v / 6; end
      for (int j = 0; j < 6; j++)
        for (int m = j + 1; m < 6; m++) if (d[j] == d[m]) uniq = 0;
      if (uniq) begin
        s = '{default: 0};
        s[0] = 0; s[7] = 7;
        for (int j = 0; j < 6; j++) s[j + 1] = d[j];
        e = ref_idx(s, 8);
        for (int i = 0; i < 8; i++) begin
          @(negedge clk);
          in_valid = 1; in_term = s[i][N-1:0]; in_last = (i == 7);
        end
        @(negedge clk);
        in_valid = 0; in_last = 0;
        if (res_pass) passes++;
        if (!res_valid || res_pass != (e < 0) || int'(res_idx) != (e < 0 ? 0 : e)) begin
          bad++;
          if (bad < 4)
            $display("FAIL R10 order %0d actual pass=%0d idx=%0d expected pass=%0d idx=%0d",
                     k, res_pass, res_idx, e < 0, e < 0 ? 0 : e);
        end
      end
    end
    checks++;
    if (bad != 0) fails++;
    chk("R10 pass count", passes, 48);
  endtask

  initial begin
    t_reset();
    t_directed();
    t_back_to_back();
    t_exhaustive();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule